// File: doc/BRIEF.md
# Misaligned Access Alignment Unit

This unit sits between the load/store stage of a processor and a little-endian memory organised in data words (32 bits by default). It accepts one word or halfword request at a time at any byte address. It turns each request into one or two word-aligned memory beats with per-byte write enables. It then returns the formatted load data, or a fault, together with a one-cycle completion pulse.

Two interpretations of a misaligned address are available, selected by `mode_seq`.

- **Rotating mode** (`mode_seq`=0) never leaves the enclosing word. A word load returns the aligned word rotated. A word store is forced onto the word boundary.
- **Byte-sequential mode** (`mode_seq`=1) touches exactly the requested byte range. That range may run into the next word, in which case two beats are needed.

Further controls:

- `chk_en` turns any misaligned access into a fault, and no memory beat is issued.
- `req_multi` marks an element of a multiple-register transfer. In byte-sequential mode such a request faults whenever it is not word-aligned.

Top module: `align_unit`

## Requirements
- R1: With `mode_seq`=0, a word load (`req_word`=1) at byte offset k reads the word at the address with bits [1:0] cleared and returns it rotated right by 8·k bits, in a single memory beat.
- R2: With `mode_seq`=1, a word load at address A returns byte A in bits [7:0] up to byte A+3 in bits [31:24]. When the range crosses a word boundary, two beats are issued: the lower word address first, then that address plus 4.
- R3: With `mode_seq`=0, a word store ignores address bits [1:0] and writes all four bytes of `req_wdata` unchanged to the aligned word, with `mem_be`=4'b1111 and one beat.
- R4: With `mode_seq`=1, a word store writes `req_wdata` bits [7:0] to byte A, up to bits [31:24] to byte A+3. Bytes outside A..A+3 in the touched words keep their values.
- R5: With `mode_seq`=1, a halfword access (`req_word`=0) at an odd address touches bytes A and A+1 only, using two beats when they lie in different words.
- R6: With `chk_en`=1, any of the following completes with `rsp_fault`=1 and no memory beat: a word or multiple request with address[1:0]≠0, or a halfword request with address[0]=1. Aligned requests proceed normally.
- R7: With `mode_seq`=1, a request with `req_multi`=1 and address[1:0]≠0 faults with no memory beat, even when `chk_en`=0.
- R8: With `mode_seq`=0 and `chk_en`=0, a request with `req_multi`=1 is a word access that treats address[1:0] as zero: no rotation for loads, an aligned full-word write for stores, and no fault.
- R9: With `mode_seq`=0, a halfword access treats address[0] as zero. It reads or writes bytes (A & ~1) and (A & ~1)+1 only.
- R10: Halfword load data is zero-extended when `req_signed`=0 and sign-extended from bit 15 when `req_signed`=1.
- R11: `req_ready` is high only while no request is in flight. `rsp_done` is a single-cycle pulse per request. A memory beat is held stable until `mem_ready`.
- R12: After reset, `req_ready`=1, `mem_valid`=0 and `rsp_done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_seq | input | 1 | 1 = byte-sequential, 0 = rotating |
| chk_en | input | 1 | Alignment fault enable |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request accepted when valid |
| req_addr | input | AW | Byte address |
| req_write | input | 1 | 1 = store, 0 = load |
| req_word | input | 1 | 1 = word, 0 = halfword |
| req_signed | input | 1 | Sign-extend halfword load |
| req_multi | input | 1 | Element of a multiple transfer (word sized) |
| req_wdata | input | DW | Store data, halfword in low bits |
| mem_valid | output | 1 | Memory beat request |
| mem_ready | input | 1 | Beat completes this cycle; read data valid |
| mem_addr | output | AW | Word-aligned beat address |
| mem_write | output | 1 | Beat is a write |
| mem_be | output | DW/8 | Per-byte write enables |
| mem_wdata | output | DW | Beat write data |
| mem_rdata | input | DW | Beat read data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_fault | output | 1 | Request faulted (valid with rsp_done) |
| rsp_rdata | output | DW | Load result (zero for stores and faults) |

## Verification
The latched decode (byte shift, lane mask, two-beat flag) is invisible until the response, so a wrong value there surfaces at `rsp_done` as a byte-permuted or wrongly extended result. It also shows in the bench memory as a neighbour byte overwritten during the same request. A wrong beat count or beat order shows within the request as an extra or missing `mem_valid` cycle, or a second address that is not the first plus 4. A stuck state shows at once as `req_ready` staying low or `rsp_done` lasting two cycles.

// File: rtl/align_pkg.sv
package align_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LO   = 2'd1,
      ST_HI   = 2'd2,
      ST_RESP = 2'd3
   } align_state_e;
endpackage

// File: rtl/align_decode.sv
module align_decode #(
   parameter int DW = 32,
   parameter int AW = 32
) (
   input  logic [AW-1:0]     i_addr,
   input  logic              i_word,
   input  logic              i_multi,
   input  logic              i_seq,
   input  logic              i_chk,
   input  logic [DW-1:0]     i_wdata,
   output logic              o_fault,
   output logic              o_two,
   output logic [AW-1:0]     o_base,
   output logic [$clog2(DW/8)-1:0] o_rsh,
   output logic [2*(DW/8)-1:0]     o_be,
   output logic [2*DW-1:0]   o_wd
);
   localparam int NB  = DW / 8;
   localparam int OB  = $clog2(NB);
   localparam int HB  = NB / 2;
   localparam int HOB = $clog2(HB);

   logic [OB-1:0] off, start, half_start;
   logic [OB:0]   nby;
   logic          word_acc, half_mis, mis;
   logic [2*NB-1:0] lane_mask;

   assign off      = i_addr[OB-1:0];
   assign word_acc = i_word | i_multi;
   assign nby      = word_acc ? (OB+1)'(NB) : (OB+1)'(HB);

   // halfword boundary: low HOB offset bits must be clear
   generate
      if (HOB > 0) begin : g_half_chk
         assign half_mis   = |off[HOB-1:0];
         assign half_start = {off[OB-1:HOB], {HOB{1'b0}}};
      end else begin : g_half_byte
         assign half_mis   = 1'b0;
         assign half_start = off;
      end
   endgenerate

   assign mis     = word_acc ? (|off) : half_mis;
   assign o_fault = (i_chk & mis) | (i_seq & i_multi & (|off));
   assign o_base  = {i_addr[AW-1:OB], {OB{1'b0}}};

   always_comb begin
      if (i_seq) begin
         start = off;
         o_rsh = off;
         o_two = (({1'b0, off}) + nby) > (OB+1)'(NB);
      end else if (word_acc) begin
         start = '0;
         o_rsh = i_multi ? '0 : off;
         o_two = 1'b0;
      end else begin
         start = half_start;
         o_rsh = half_start;
         o_two = 1'b0;
      end
   end

   // per-lane enable over the two-word window
   generate
      for (genvar b = 0; b < 2*NB; b++) begin : g_lane
         assign lane_mask[b] = (b >= int'(start)) && (b < int'(start) + int'(nby));
      end
   endgenerate

   assign o_be = lane_mask;
   assign o_wd = {{DW{1'b0}}, i_wdata} << {start, 3'b000};
endmodule

// File: rtl/align_format.sv
module align_format #(
   parameter int DW = 32
) (
   input  logic [DW-1:0]           i_lo,
   input  logic [DW-1:0]           i_hi,
   input  logic                    i_use_hi,
   input  logic [$clog2(DW/8)-1:0] i_rsh,
   input  logic                    i_half,
   input  logic                    i_sext,
   output logic [DW-1:0]           o_data
);
   localparam int HW = DW / 2;

   logic [2*DW-1:0] wide;
   logic [DW-1:0]   w;
   logic [HW-1:0]   h;

   // upper half equal to lower half gives a rotation within one word
   assign wide = {(i_use_hi ? i_hi : i_lo), i_lo} >> {i_rsh, 3'b000};
   assign w    = wide[DW-1:0];
   assign h    = w[HW-1:0];

   always_comb begin
      if (i_half) o_data = {{HW{i_sext & h[HW-1]}}, h};
      else        o_data = w;
   end
endmodule

// File: rtl/align_unit.sv
module align_unit #(
   parameter int DW = 32,
   parameter int AW = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_seq,
   input  logic              chk_en,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [AW-1:0]     req_addr,
   input  logic              req_write,
   input  logic              req_word,
   input  logic              req_signed,
   input  logic              req_multi,
   input  logic [DW-1:0]     req_wdata,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic [AW-1:0]     mem_addr,
   output logic              mem_write,
   output logic [DW/8-1:0]   mem_be,
   output logic [DW-1:0]     mem_wdata,
   input  logic [DW-1:0]     mem_rdata,
   output logic              rsp_done,
   output logic              rsp_fault,
   output logic [DW-1:0]     rsp_rdata
);
   import align_pkg::*;

   localparam int NB = DW / 8;
   localparam int OB = $clog2(NB);

   generate
      if (DW < 32 || (DW & (DW - 1)) != 0) begin : g_bad_dw
         $error("align_unit: DW must be a power of two of at least 32");
      end
      if (AW <= OB) begin : g_bad_aw
         $error("align_unit: AW must exceed the byte-offset width");
      end
   endgenerate

   align_state_e st;

   logic            d_fault, d_two;
   logic [AW-1:0]   d_base;
   logic [OB-1:0]   d_rsh;
   logic [2*NB-1:0] d_be;
   logic [2*DW-1:0] d_wd;

   logic            r_fault, r_two, r_write, r_half, r_sext;
   logic [AW-1:0]   r_base;
   logic [OB-1:0]   r_rsh;
   logic [2*NB-1:0] r_be;
   logic [2*DW-1:0] r_wd;
   logic [DW-1:0]   lo_q, hi_q, fmt;

   align_decode #(.DW(DW), .AW(AW)) u_dec (
      .i_addr  (req_addr),
      .i_word  (req_word),
      .i_multi (req_multi),
      .i_seq   (mode_seq),
      .i_chk   (chk_en),
      .i_wdata (req_wdata),
      .o_fault (d_fault),
      .o_two   (d_two),
      .o_base  (d_base),
      .o_rsh   (d_rsh),
      .o_be    (d_be),
      .o_wd    (d_wd)
   );

   align_format #(.DW(DW)) u_fmt (
      .i_lo     (lo_q),
      .i_hi     (hi_q),
      .i_use_hi (r_two),
      .i_rsh    (r_rsh),
      .i_half   (r_half),
      .i_sext   (r_sext),
      .o_data   (fmt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         r_fault <= 1'b0;
         r_two   <= 1'b0;
         r_write <= 1'b0;
         r_half  <= 1'b0;
         r_sext  <= 1'b0;
         r_base  <= '0;
         r_rsh   <= '0;
         r_be    <= '0;
         r_wd    <= '0;
         lo_q    <= '0;
         hi_q    <= '0;
      end else begin
         unique case (st)
            ST_IDLE: if (req_valid) begin
               r_fault <= d_fault;
               r_two   <= d_two;
               r_write <= req_write;
               r_half  <= ~(req_word | req_multi);
               r_sext  <= req_signed;
               r_base  <= d_base;
               r_rsh   <= d_rsh;
               r_be    <= d_be;
               r_wd    <= d_wd;
               st      <= d_fault ? ST_RESP : ST_LO;
            end
            ST_LO: if (mem_ready) begin
               lo_q <= mem_rdata;
               st   <= r_two ? ST_HI : ST_RESP;
            end
            ST_HI: if (mem_ready) begin
               hi_q <= mem_rdata;
               st   <= ST_RESP;
            end
            ST_RESP: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (st == ST_IDLE);
   assign mem_valid = (st == ST_LO) || (st == ST_HI);
   assign mem_write = mem_valid & r_write;
   assign mem_addr  = (st == ST_HI) ? r_base + AW'(NB) : r_base;
   assign mem_be    = (st == ST_HI) ? r_be[2*NB-1:NB] : r_be[NB-1:0];
   assign mem_wdata = (st == ST_HI) ? r_wd[2*DW-1:DW] : r_wd[DW-1:0];
   assign rsp_done  = (st == ST_RESP);
   assign rsp_fault = rsp_done & r_fault;
   assign rsp_rdata = (rsp_done && !r_write && !r_fault) ? fmt : '0;

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   // R11
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R11
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_be)));

   // R6
   fault_nobeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && rsp_fault) |-> !$past(mem_valid));

   // R4
   store_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_write) |-> (mem_be != '0));

   // R2
   beat_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> (mem_addr[OB-1:0] == '0));
endmodule

// File: tb/sim_align_unit.sv
`timescale 1ns/1ps
module sim_align_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_seq = 1'b0, chk_en = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b1;
   logic        req_signed = 1'b0, req_multi = 1'b0;
   logic [31:0] req_addr = '0, req_wdata = '0;
   logic        req_ready, mem_valid, mem_ready, mem_write;
   logic [31:0] mem_addr, mem_wdata, mem_rdata, rsp_rdata;
   logic [3:0]  mem_be;
   logic        rsp_done, rsp_fault;

   int n_chk = 0, n_bad = 0;

   logic [7:0]  mem [0:63];
   logic        stall_en = 1'b0, gap = 1'b0;
   int unsigned btot = 0;
   logic [31:0] blog [0:7];

   always #4 clk = ~clk;

   align_unit u0 (
      .clk(clk), .rst_n(rst_n), .mode_seq(mode_seq), .chk_en(chk_en),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_write(req_write), .req_word(req_word), .req_signed(req_signed),
      .req_multi(req_multi), .req_wdata(req_wdata),
      .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
      .mem_write(mem_write), .mem_be(mem_be), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .rsp_done(rsp_done), .rsp_fault(rsp_fault),
      .rsp_rdata(rsp_rdata)
   );

   assign mem_ready = ~gap;
   assign mem_rdata = {mem[{mem_addr[5:2], 2'd3}], mem[{mem_addr[5:2], 2'd2}],
                       mem[{mem_addr[5:2], 2'd1}], mem[{mem_addr[5:2], 2'd0}]};

   always @(posedge clk) begin
      gap <= stall_en ? ~gap : 1'b0;
      if (mem_valid && mem_ready) begin
         blog[btot[2:0]] <= mem_addr;
         btot <= btot + 1;
         if (mem_write)
            for (int b = 0; b < 4; b++)
               if (mem_be[b]) mem[{mem_addr[5:2], 2'(b)}] <= mem_wdata[8*b +: 8];
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   task automatic init_mem();
      for (int i = 0; i < 64; i++) mem[i] = 8'(i + 1);
   endtask

   task automatic do_req(input logic seq, input logic chk, input logic [31:0] addr,
                         input logic wr, input logic word, input logic sx,
                         input logic multi, input logic [31:0] wd,
                         output logic [31:0] rd, output logic flt,
                         output int beats, output logic [31:0] a0, output logic [31:0] a1);
      int unsigned b0;
      int n;
      @(negedge clk);
      mode_seq = seq; chk_en = chk; req_addr = addr; req_write = wr;
      req_word = word; req_signed = sx; req_multi = multi; req_wdata = wd;
      req_valid = 1'b1;
      b0 = btot;
      @(negedge clk);
      req_valid = 1'b0;
      check("R11 busy", {31'd0, req_ready}, 32'd0);
      n = 0;
      while (!rsp_done && n < 64) begin
         @(negedge clk);
         n++;
      end
      rd = rsp_rdata; flt = rsp_fault;
      beats = int'(btot - b0);
      a0 = blog[b0[2:0]]; a1 = blog[3'(b0 + 1)];
      if (n >= 64) check("R11 timeout", 32'd1, 32'd0);
      @(negedge clk);
      check("R11 pulse", {31'd0, rsp_done}, 32'd0);
   endtask

   logic [31:0] rd, a0, a1;
   logic        flt;
   int          nb;

   task automatic t_reset();
      check("R12 ready", {31'd0, req_ready}, 32'd1);
      check("R12 mem_valid", {31'd0, mem_valid}, 32'd0);
      check("R12 done", {31'd0, rsp_done}, 32'd0);
   endtask

   task automatic t_rotate_load();
      init_mem();
      do_req(1'b0, 1'b0, 32'h11, 1'b0, 1'b1, 1'b0, 1'b0, 0, rd, flt, nb, a0, a1);
      check("R1 rot1", rd, 32'h11141312);
      check("R1 beats", 32'(nb), 32'd1);
      check("R1 addr", a0, 32'h10);
      do_req(1'b0, 1'b0, 32'h13, 1'b0, 1'b1, 1'b0, 1'b0, 0, rd, flt, nb, a0, a1);
      check("R1 rot3", rd, 32'h13121114);
   endtask

   task automatic t_seq_load();
      init_mem();
      do_req(1'b1, 1'b0, 32'h11, 1'b0, 1'b1, 1'b0, 1'b0, 0, rd, flt, nb, a0, a1);
      check("R2 seq1", rd, 32'h15141312);
      check("R2 beats", 32'(nb), 32'd2);
      check("R2 lo first", a0, 32'h10);
      check("R2 hi second", a1, 32'h14);
      do_req(1'b1, 1'b0, 32'h13, 1'b0, 1'b1, 1'b0, 1'b0, 0, rd, flt, nb, a0, a1);
      check("R2 seq3", rd, 32'h17161514);
      do_req(1'b1, 1'b0, 32'h10, 1'b0, 1'b1, 1'b0, 1'b0, 0, rd, flt, nb, a0, a1);
      check("R2 aligned", rd, 32'h14131211);
      check("R11 single beat", 32'(nb), 32'd1);
      stall_en = 1'b1;
      do_req(1'b1, 1'b0, 32'h11, 1'b0, 1'b1, 1'b0, 1'b0, 0, rd, flt, nb, a0, a1);
      stall_en = 1'b0;
      check("R11 stalled result", rd, 32'h15141312);
      check("R11 stalled beats", 32'(nb), 32'd2);
   endtask

   task automatic t_rotate_store();
      init_mem();
      do_req(1'b0, 1'b0, 32'h21, 1'b1, 1'b1, 1'b0, 1'b0, 32'hAABBCCDD, rd, flt, nb, a0, a1);
      check("R3 word", {mem[8'h23], mem[8'h22], mem[8'h21], mem[8'h20]}, 32'hAABBCCDD);
      check("R3 neighbour", {24'd0, mem[8'h24]}, 32'h25);
      check("R3 beats", 32'(nb), 32'd1);
   endtask

   task automatic t_seq_store();
      init_mem();
      do_req(1'b1, 1'b0, 32'h22, 1'b1, 1'b1, 1'b0, 1'b0, 32'h11223344, rd, flt, nb, a0, a1);
      check("R4 bytes", {mem[8'h25], mem[8'h24], mem[8'h23], mem[8'h22]}, 32'h11223344);
      check("R4 keep low", {24'd0, mem[8'h21]}, 32'h22);
      check("R4 keep high", {24'd0, mem[8'h26]}, 32'h27);
      check("R4 beats", 32'(nb), 32'd2);
   endtask

   task automatic t_seq_half();
      init_mem();
      do_req(1'b1, 1'b0, 32'h13, 1'b0, 1'b0, 1'b0, 1'b0, 0, rd, flt, nb, a0, a1);
      check("R5 cross load", rd, 32'h00001514);
      check("R5 cross beats", 32'(nb), 32'd2);
      do_req(1'b1, 1'b0, 32'h11, 1'b0, 1'b0, 1'b0, 1'b0, 0, rd, flt, nb, a0, a1);
      check("R5 inner load", rd, 32'h00001312);
      check("R5 inner beats", 32'(nb), 32'd1);
      do_req(1'b1, 1'b0, 32'h27, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000BEEF, rd, flt, nb, a0, a1);
      check("R5 store", {16'd0, mem[8'h28], mem[8'h27]}, 32'h0000BEEF);
      check("R5 keep", {16'd0, mem[8'h29], mem[8'h26]}, 32'h00002A27);
   endtask

   task automatic t_checks();
      init_mem();
      do_req(1'b0, 1'b1, 32'h12, 1'b0, 1'b1, 1'b0, 1'b0, 0, rd, flt, nb, a0, a1);
      check("R6 word fault", {31'd0, flt}, 32'd1);
      check("R6 no beat", 32'(nb), 32'd0);
      do_req(1'b1, 1'b1, 32'h11, 1'b0, 1'b0, 1'b0, 1'b0, 0, rd, flt, nb, a0, a1);
      check("R6 half fault", {31'd0, flt}, 32'd1);
      do_req(1'b1, 1'b1, 32'h12, 1'b0, 1'b0, 1'b0, 1'b0, 0, rd, flt, nb, a0, a1);
      check("R6 half ok", {31'd0, flt}, 32'd0);
      check("R6 half data", rd, 32'h00001413);
      do_req(1'b1, 1'b1, 32'h21, 1'b1, 1'b1, 1'b0, 1'b0, 32'hFFFFFFFF, rd, flt, nb, a0, a1);
      check("R6 store blocked", {mem[8'h24], mem[8'h23], mem[8'h22], mem[8'h21]}, 32'h25242322);
   endtask

   task automatic t_multi();
      init_mem();
      do_req(1'b1, 1'b0, 32'h15, 1'b0, 1'b1, 1'b0, 1'b1, 0, rd, flt, nb, a0, a1);
      check("R7 seq multi fault", {31'd0, flt}, 32'd1);
      check("R7 no beat", 32'(nb), 32'd0);
      do_req(1'b1, 1'b0, 32'h14, 1'b0, 1'b1, 1'b0, 1'b1, 0, rd, flt, nb, a0, a1);
      check("R7 aligned ok", rd, 32'h18171615);
      do_req(1'b0, 1'b0, 32'h15, 1'b0, 1'b1, 1'b0, 1'b1, 0, rd, flt, nb, a0, a1);
      check("R8 load", rd, 32'h18171615);
      check("R8 no fault", {31'd0, flt}, 32'd0);
      do_req(1'b0, 1'b0, 32'h17, 1'b1, 1'b1, 1'b0, 1'b1, 32'hDEADBEEF, rd, flt, nb, a0, a1);
      check("R8 store", {mem[8'h17], mem[8'h16], mem[8'h15], mem[8'h14]}, 32'hDEADBEEF);
   endtask

   task automatic t_rotate_half();
      init_mem();
      do_req(1'b0, 1'b0, 32'h11, 1'b0, 1'b0, 1'b0, 1'b0, 0, rd, flt, nb, a0, a1);
      check("R9 odd low", rd, 32'h00001211);
      do_req(1'b0, 1'b0, 32'h13, 1'b0, 1'b0, 1'b0, 1'b0, 0, rd, flt, nb, a0, a1);
      check("R9 odd high", rd, 32'h00001413);
      do_req(1'b0, 1'b0, 32'h33, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000CAFE, rd, flt, nb, a0, a1);
      check("R9 store", {mem[8'h34], mem[8'h33], mem[8'h32], mem[8'h31]}, 32'h35CAFE32);
   endtask

   task automatic t_extend();
      init_mem();
      mem[8'h30] = 8'h9A; mem[8'h31] = 8'hF0;
      do_req(1'b1, 1'b0, 32'h30, 1'b0, 1'b0, 1'b1, 1'b0, 0, rd, flt, nb, a0, a1);
      check("R10 signed", rd, 32'hFFFFF09A);
      do_req(1'b1, 1'b0, 32'h30, 1'b0, 1'b0, 1'b0, 1'b0, 0, rd, flt, nb, a0, a1);
      check("R10 unsigned", rd, 32'h0000F09A);
      do_req(1'b1, 1'b0, 32'h2F, 1'b0, 1'b0, 1'b1, 1'b0, 0, rd, flt, nb, a0, a1);
      check("R10 signed cross", rd, 32'hFFFF9A30);
   endtask

   initial begin
      #(8 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      init_mem();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_rotate_load();
      t_seq_load();
      t_rotate_store();
      t_seq_store();
      t_seq_half();
      t_checks();
      t_multi();
      t_rotate_half();
      t_extend();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule